// File: doc/BRIEF.md
# Loop Oscillator Power Sequencer

This block brings a frequency-locked loop and its current-controlled oscillator up and down in a safe order. It also drives the code that picks the output clock source. An enable request switches the oscillator on first. The sequencer then waits for the oscillator to report ready and for the reference clock to report stable, and only then switches the loop on. While the source code is in automatic mode, the selected output moves from the reference clock to the loop output as soon as the loop reports lock.

A disable request first forces the source code to the reference clock and waits for a one-cycle read-back echo of that code to confirm the write. It then waits until at least ten ticks of the reference clock and at least ten ticks of the loop output clock have been counted. This covers whichever of the two clocks is slower. Only after that does it drop the loop enable. On the next cycle it drops the oscillator enable and returns the code to automatic mode. It waits for the echo to confirm that write as well, then waits three reference ticks before it reports completion. The clock ticks arrive as single-cycle pulses in the controller's clock domain. The select output is a plain control level and is not a glitch-free switch.

Top module: `fll_power_sequencer`

## Requirements
- R1: After reset, osc_en, loop_en, sel_loop, busy and done are 0 and bypass_code is 2'b00 (automatic).
- R2: A req_on pulse while powered off sets osc_en and busy on the next cycle, with loop_en held at 0. bypass_code stays 2'b00 throughout the enable order.
- R3: loop_en rises only after osc_ready has been seen and then ref_stable has been seen, in that order; ref_stable alone does not advance the order. loop_en is never 1 while osc_en is 0.
- R4: Source codes are 2'b00 automatic, 2'b01 forced reference and 2'b10 forced loop. sel_loop is 1 under 2'b10, 0 under 2'b01, and under 2'b00 it equals loop_locked while loop_en is 1. With loop running and no request active, force_loop=1 sets code 2'b10 on the next cycle and force_loop=0 sets 2'b00.
- R5: A req_off pulse while running sets bypass_code to 2'b01 on the next cycle. loop_en stays 1 until the echo confirms that code.
- R6: After the confirmation, loop_en falls only once at least 10 ref_tick pulses and at least 10 out_tick pulses have been counted. Nine of either one keeps it at 1.
- R7: The cycle after loop_en falls, osc_en falls and bypass_code returns to 2'b00.
- R8: After 2'b00 is confirmed, busy stays 1 until 3 ref_tick pulses have been counted. Fewer pulses give no done.
- R9: req_on is ignored unless powered off, and req_off is ignored unless running. An ignored request changes no output and leaves nothing pending.
- R10: done is a single-cycle pulse at the end of each enable order and each disable order. busy is 0 while powered off or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_on | input | 1 | Start the power-up order |
| req_off | input | 1 | Start the power-down order |
| osc_ready | input | 1 | Oscillator reports ready |
| ref_stable | input | 1 | Reference clock reports stable |
| loop_locked | input | 1 | Loop reports frequency lock |
| force_loop | input | 1 | While running, select the loop output without waiting for lock |
| ref_tick | input | 1 | One pulse per reference clock cycle |
| out_tick | input | 1 | One pulse per loop output clock cycle |
| osc_en | output | 1 | Oscillator enable |
| loop_en | output | 1 | Loop enable |
| bypass_code | output | 2 | Source selection code |
| sel_loop | output | 1 | 1 selects loop output, 0 selects reference |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The in-line assertions check on every cycle the invariants that hold regardless of timing. These are: the loop is never enabled without the oscillator, loop_en rises only after ref_stable, and the forced-reference code is held and echoed for the whole counting window. They also check that loop_en falls only when both window counters are full, that the oscillator drops strictly after the loop, and that done never lasts two cycles. The bench scenarios show the things only a sequence can reveal. These include the exact counts that are enough or one short on each clock, the delay introduced by read-back confirmation, requests ignored in the wrong phase, and that lock is followed only in automatic mode.

// File: rtl/fllseq_pkg.sv
`timescale 1ns/1ps
package fllseq_pkg;
   typedef enum logic [1:0] {
      BYP_AUTO = 2'b00,
      BYP_REF  = 2'b01,
      BYP_LOOP = 2'b10
   } byp_e;

   typedef enum logic [3:0] {
      S_OFF,
      S_OSC_WAIT,
      S_REF_WAIT,
      S_ON,
      S_CONF_REF,
      S_WINDOW,
      S_OSC_DROP,
      S_CONF_AUTO,
      S_SETTLE
   } seq_e;
endpackage

// File: rtl/fllseq_tick_count.sv
`timescale 1ns/1ps
module fllseq_tick_count #(
   parameter int unsigned LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic reached
);
   localparam int unsigned W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM_V = W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("fllseq_tick_count: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != LIM_V)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign reached = (cnt_q == LIM_V);

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_V);
   assert_reach_by_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reached) |-> $past(tick) && $past(run));
endmodule

// File: rtl/fllseq_echo.sv
`timescale 1ns/1ps
module fllseq_echo
   import fllseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  byp_e wr_code,
   output byp_e rd_code
);
   always_ff @(posedge clk) begin
      if (!rst_n) rd_code <= BYP_AUTO;
      else        rd_code <= wr_code;
   end
endmodule

// File: rtl/fllseq_select.sv
`timescale 1ns/1ps
module fllseq_select
   import fllseq_pkg::*;
#(
   parameter bit SEL_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  byp_e code,
   input  logic loop_en,
   input  logic loop_locked,
   output logic sel_loop
);
   logic sel_next;

   always_comb begin
      unique case (code)
         BYP_LOOP: sel_next = 1'b1;
         BYP_REF:  sel_next = 1'b0;
         default:  sel_next = loop_en & loop_locked;
      endcase
   end

   if (SEL_REG) begin : g_reg
      logic sel_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sel_q <= 1'b0;
         else        sel_q <= sel_next;
      end
      assign sel_loop = sel_q;
      assert_sel_ref_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (code == BYP_REF) |=> !sel_loop);
   end else begin : g_comb
      assign sel_loop = sel_next;
      assert_sel_ref_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (code == BYP_REF) |-> !sel_loop);
   end
endmodule

// File: rtl/fllseq_ctrl.sv
`timescale 1ns/1ps
module fllseq_ctrl
   import fllseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_on,
   input  logic req_off,
   input  logic osc_ready,
   input  logic ref_stable,
   input  logic force_loop,
   input  byp_e echo_code,
   input  logic win_done,
   input  logic settle_done,
   output logic osc_en,
   output logic loop_en,
   output byp_e byp_code,
   output logic busy,
   output logic done,
   output logic win_run,
   output logic settle_run
);
   seq_e st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_OFF;
         osc_en   <= 1'b0;
         loop_en  <= 1'b0;
         byp_code <= BYP_AUTO;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            S_OFF: begin
               byp_code <= BYP_AUTO;
               if (req_on) begin
                  osc_en <= 1'b1;
                  st_q   <= S_OSC_WAIT;
               end
            end
            S_OSC_WAIT: begin
               if (osc_ready) st_q <= S_REF_WAIT;
            end
            S_REF_WAIT: begin
               if (ref_stable) begin
                  loop_en <= 1'b1;
                  done    <= 1'b1;
                  st_q    <= S_ON;
               end
            end
            S_ON: begin
               if (req_off) begin
                  byp_code <= BYP_REF;
                  st_q     <= S_CONF_REF;
               end else begin
                  byp_code <= force_loop ? BYP_LOOP : BYP_AUTO;
               end
            end
            S_CONF_REF: begin
               if (echo_code == BYP_REF) st_q <= S_WINDOW;
            end
            S_WINDOW: begin
               if (win_done) begin
                  loop_en <= 1'b0;
                  st_q    <= S_OSC_DROP;
               end
            end
            S_OSC_DROP: begin
               osc_en   <= 1'b0;
               byp_code <= BYP_AUTO;
               st_q     <= S_CONF_AUTO;
            end
            S_CONF_AUTO: begin
               if (echo_code == BYP_AUTO) st_q <= S_SETTLE;
            end
            S_SETTLE: begin
               if (settle_done) begin
                  done <= 1'b1;
                  st_q <= S_OFF;
               end
            end
            default: st_q <= S_OFF;
         endcase
      end
   end

   assign busy       = (st_q != S_OFF) && (st_q != S_ON);
   assign win_run    = (st_q == S_WINDOW);
   assign settle_run = (st_q == S_SETTLE);

   assert_loop_needs_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> osc_en);
   assert_loop_rise_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loop_en) |-> $past(ref_stable) && $past(osc_en));
   assert_auto_while_enabling_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_OSC_WAIT || st_q == S_REF_WAIT) |-> (byp_code == BYP_AUTO));
   assert_ref_held_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WINDOW) |-> (byp_code == BYP_REF) && (echo_code == BYP_REF) && loop_en);
   assert_loop_fall_after_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loop_en) |-> $past(win_done));
   assert_osc_fall_after_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_en) |-> !loop_en && !$past(loop_en));
   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/fll_power_sequencer.sv
`timescale 1ns/1ps
module fll_power_sequencer
   import fllseq_pkg::*;
#(
   parameter int unsigned SLOW_TICKS   = 10,
   parameter int unsigned SETTLE_TICKS = 3,
   parameter bit          SEL_REG      = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_on,
   input  logic       req_off,
   input  logic       osc_ready,
   input  logic       ref_stable,
   input  logic       loop_locked,
   input  logic       force_loop,
   input  logic       ref_tick,
   input  logic       out_tick,
   output logic       osc_en,
   output logic       loop_en,
   output logic [1:0] bypass_code,
   output logic       sel_loop,
   output logic       busy,
   output logic       done
);
   localparam int unsigned N_WIN = 2;

   if (SLOW_TICKS < 1) begin : g_bad_slow
      $error("fll_power_sequencer: SLOW_TICKS must be at least 1");
   end
   if (SETTLE_TICKS < 1) begin : g_bad_settle
      $error("fll_power_sequencer: SETTLE_TICKS must be at least 1");
   end

   byp_e             code_w;
   byp_e             echo_w;
   logic             win_run;
   logic             settle_run;
   logic             settle_hit;
   logic [N_WIN-1:0] win_tick;
   logic [N_WIN-1:0] win_hit;

   assign win_tick = {out_tick, ref_tick};

   for (genvar i = 0; i < N_WIN; i++) begin : g_win
      fllseq_tick_count #(.LIMIT(SLOW_TICKS)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (win_run),
         .tick    (win_tick[i]),
         .reached (win_hit[i])
      );
   end

   fllseq_tick_count #(.LIMIT(SETTLE_TICKS)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (settle_run),
      .tick    (ref_tick),
      .reached (settle_hit)
   );

   fllseq_echo u_echo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_code (code_w),
      .rd_code (echo_w)
   );

   fllseq_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_on      (req_on),
      .req_off     (req_off),
      .osc_ready   (osc_ready),
      .ref_stable  (ref_stable),
      .force_loop  (force_loop),
      .echo_code   (echo_w),
      .win_done    (&win_hit),
      .settle_done (settle_hit),
      .osc_en      (osc_en),
      .loop_en     (loop_en),
      .byp_code    (code_w),
      .busy        (busy),
      .done        (done),
      .win_run     (win_run),
      .settle_run  (settle_run)
   );

   fllseq_select #(.SEL_REG(SEL_REG)) u_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .code        (code_w),
      .loop_en     (loop_en),
      .loop_locked (loop_locked),
      .sel_loop    (sel_loop)
   );

   assign bypass_code = code_w;

   assert_settle_in_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
      settle_run |-> (code_w == BYP_AUTO) && !osc_en && busy);
endmodule

// File: tb/fll_power_sequencer_bench.sv
`timescale 1ns/1ps
module fll_power_sequencer_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_on = 0, req_off = 0, osc_ready = 0, ref_stable = 0;
   logic loop_locked = 0, force_loop = 0, ref_tick = 0, out_tick = 0;
   logic osc_en, loop_en, sel_loop, busy, done;
   logic [1:0] bypass_code;

   int checks = 0;
   int fails = 0;
   int done_cnt = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   fll_power_sequencer u_fll_power_sequencer (
      .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
      .osc_ready(osc_ready), .ref_stable(ref_stable), .loop_locked(loop_locked),
      .force_loop(force_loop), .ref_tick(ref_tick), .out_tick(out_tick),
      .osc_en(osc_en), .loop_en(loop_en), .bypass_code(bypass_code),
      .sel_loop(sel_loop), .busy(busy), .done(done)
   );

   always @(posedge clk) if (rst_n && done) done_cnt++;

   // {req_on, req_off, osc_ready, ref_stable, exp osc_en, exp loop_en, exp busy, exp done}
   localparam logic [7:0] VEC [9] = '{
      8'b0000_0000, 8'b1000_1010, 8'b0000_1010, 8'b0100_1010, 8'b0010_1010,
      8'b0010_1010, 8'b0011_1101, 8'b0011_1100, 8'b1011_1100
   };

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick_burst(input int nref, input int nout);
      for (int i = 0; i < 12; i++) begin
         ref_tick = (i < nref);
         out_tick = (i < nout);
         if (i < nref || i < nout) step(1);
      end
      ref_tick = 0;
      out_tick = 0;
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      int d0;
      step(3);
      // R1 reset state
      chk("R1 osc_en", osc_en, 0);
      chk("R1 loop_en", loop_en, 0);
      chk("R1 bypass_code", bypass_code, 0);
      chk("R1 sel_loop", sel_loop, 0);
      chk("R1 busy/done", {busy, done}, 0);
      rst_n = 1;
      step(1);

      // Table: enable order (R2, R3, R9, R10)
      for (int v = 0; v < 9; v++) begin
         {req_on, req_off, osc_ready, ref_stable} = VEC[v][7:4];
         step(1);
         chk($sformatf("R2/R3 vec%0d osc_en", v), osc_en, VEC[v][3]);
         chk($sformatf("R3/R9 vec%0d loop_en", v), loop_en, VEC[v][2]);
         chk($sformatf("R10 vec%0d busy", v), busy, VEC[v][1]);
         chk($sformatf("R10 vec%0d done", v), done, VEC[v][0]);
         chk($sformatf("R2 vec%0d bypass_code", v), bypass_code, 0);
      end
      req_on = 0;

      // R4 selection in running state
      loop_locked = 0; #1;
      chk("R4 auto unlocked sel", sel_loop, 0);
      loop_locked = 1; #1;
      chk("R4 auto locked sel", sel_loop, 1);
      force_loop = 1; loop_locked = 0;
      step(1);
      chk("R4 forced loop code", bypass_code, 2);
      chk("R4 forced loop sel without lock", sel_loop, 1);
      force_loop = 0;
      step(1);
      chk("R4 back to auto code", bypass_code, 0);
      chk("R4 auto unlocked sel again", sel_loop, 0);
      loop_locked = 1;

      // Disable order, reference clock slower
      req_off = 1; step(1); req_off = 0;
      chk("R5 forced ref code", bypass_code, 1);
      chk("R4 ref code sel low while locked", sel_loop, 0);
      chk("R5 loop held", loop_en, 1);
      chk("R5 busy", busy, 1);
      step(3);
      req_on = 1; step(1); req_on = 0;
      chk("R9 req_on ignored osc_en", osc_en, 1);
      chk("R9 req_on ignored code", bypass_code, 1);
      tick_burst(9, 10);
      step(3);
      chk("R6 nine ref ticks keep loop", loop_en, 1);
      tick_burst(1, 0);
      step(3);
      chk("R6 loop dropped", loop_en, 0);
      chk("R7 osc dropped", osc_en, 0);
      chk("R7 code auto", bypass_code, 0);
      chk("R8 busy during settle", busy, 1);
      step(3);
      d0 = done_cnt;
      tick_burst(2, 0);
      step(3);
      chk("R8 two ticks no done", done_cnt - d0, 0);
      chk("R8 still busy", busy, 1);
      tick_burst(1, 0);
      step(3);
      chk("R8/R10 one done pulse", done_cnt - d0, 1);
      chk("R10 done low after pulse", done, 0);
      chk("R10 idle not busy", busy, 0);
      chk("R9 no pending restart", osc_en, 0);

      // R3: ref_stable alone does not advance the order
      osc_ready = 0; ref_stable = 1;
      req_on = 1; step(1); req_on = 0;
      step(3);
      chk("R3 waits for osc_ready", loop_en, 0);
      osc_ready = 1; step(1);
      chk("R3 still one step away", loop_en, 0);
      step(1);
      chk("R3 loop up", loop_en, 1);

      // Disable order, output clock slower
      req_off = 1; step(1); req_off = 0;
      step(3);
      tick_burst(10, 9);
      step(3);
      chk("R6 nine out ticks keep loop", loop_en, 1);
      tick_burst(0, 1);
      step(3);
      chk("R6 loop dropped on out count", loop_en, 0);
      step(3);
      tick_burst(3, 0);
      step(3);
      chk("R8 second disable complete", busy, 0);

      // R1 reset while running
      req_on = 1; step(1); req_on = 0;
      step(3);
      rst_n = 0; step(1);
      chk("R1 mid-run reset", {osc_en, loop_en, bypass_code, busy, done}, 0);

      finished = 1;
      summary();
      $finish;
   end
endmodule